// File: doc/BRIEF.md
# Dual-Mode Serial Channel

This block is a serial transmit and receive channel. An 8-bit mode register sets how it works. With the mode bit clear, the channel uses asynchronous start-stop framing. A frame is one low start bit, 7 or 8 data bits sent LSB first, an optional parity bit and one or two high stop bits. The line idles high. With the mode bit set, the channel shifts exactly 8 bits LSB first and drives its own serial clock.

The host loads a byte with a one-cycle write strobe while `tx_ready` is high. Received characters appear on `rx_data` together with a one-cycle `rx_done` pulse. A parity failure raises `rx_perr` in the same cycle as `rx_done`.

Bit timing comes from a 16x oversampling tick. The tick period is `BASE_DIV` clocks, multiplied by a prescaler that the register selects.

Top module: `duplex_serial_chan`

## Requirements
- R1: The mode register resets to 0x00, and `mode_rdata` always returns the last value written through `mode_we`/`mode_wdata`. Layout: bit 7 selects clock-synchronous mode, bit 6 selects 7-bit characters, bit 5 enables parity, bit 4 selects odd parity, bit 3 selects two stop bits, and bits 1:0 select the prescaler.
- R2: In asynchronous mode, a byte written while `tx_ready` is high is sent as one low start bit, then the data LSB first, then high stop bits. `tx_ready` is low for the whole frame, and `ser_out` and `sclk_out` are high whenever the channel is idle.
- R3: With bit 6 set in asynchronous mode, only data bits 0..6 are sent. On receive, 7 bits are taken and `rx_data[7]` reads 0.
- R4: With bit 5 set in asynchronous mode, a parity bit follows the last data bit. It makes the number of ones over the data bits plus the parity bit even when bit 4 is 0, and odd when bit 4 is 1.
- R5: On receive with parity enabled, `rx_perr` pulses with `rx_done` when the received parity bit does not follow the R4 rule. With bit 5 clear, no parity bit is expected, bit 4 has no effect, and `rx_perr` stays 0.
- R6: With bit 3 set, the transmitter sends two stop bits, so the frame is one bit period longer than with bit 3 clear.
- R7: One bit period is 16 × `BASE_DIV` × D clocks, where D is 1, 4, 16 or 64 for bits 1:0 = 0, 1, 2 or 3.
- R8: In clock-synchronous mode, a written byte is sent as exactly 8 bits LSB first, with no start, stop or parity bit, whatever bits 6, 5 and 4 hold. `sclk_out` falls when each bit is put out and rises at the middle of the bit, and `ser_in` is sampled on that rising edge. After the eighth sample, `rx_done` pulses with the 8 captured bits and `rx_perr` stays 0.
- R9: A write strobe while `tx_ready` is low is ignored and produces no frame.
- R10: `rx_done` is a single-cycle pulse, and `rx_data` and `rx_perr` hold the character's result in that cycle. Each received character gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| mode_rdata | output | 8 | Mode register contents |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | High when a new byte can be accepted |
| rx_data | output | 8 | Last received character |
| rx_done | output | 1 | One-cycle pulse when a character has been received |
| rx_perr | output | 1 | Parity failure, valid with `rx_done` |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| sclk_out | output | 1 | Serial clock in synchronous mode, high otherwise |

## Verification
A looped-back transmitter always produces correct parity, so the parity-failure path cannot be reached by looping the channel's output to its input. For those cases the bench takes over the receive line. It drives frames with a deliberately inverted parity bit, including a 7-bit odd-parity frame. It also drives frames with parity disabled but the odd bit set, and checks that no failure is flagged. A second hard case is a write strobe that arrives mid-frame. The bench issues it while `tx_ready` is low and then confirms that exactly one character arrives at the receiver and that the line returns to idle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef struct packed {
    logic       sync;
    logic [3:0] nbits;
    logic       par_on;
    logic       par_odd;
    logic       two_stop;
    logic [1:0] psel;
  } dsc_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } dsc_rx_st_e;

endpackage

// File: rtl/dsc_mode_reg.sv
module dsc_mode_reg
  import dsc_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [MW-1:0] wdata,
  output logic [MW-1:0] rdata,
  output dsc_cfg_t      cfg
);

  logic [MW-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (we) mode_q <= wdata;
  end

  assign rdata = mode_q;

  // decode: synchronous mode forces 8 bits and drops parity
  always_comb begin
    cfg.sync     = mode_q[7];
    cfg.nbits    = (mode_q[6] && !mode_q[7]) ? 4'd7 : 4'd8;
    cfg.par_on   = mode_q[5] && !mode_q[7];
    cfg.par_odd  = mode_q[4];
    cfg.two_stop = mode_q[3] && !mode_q[7];
    cfg.psel     = mode_q[1:0];
  end

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_we_or_rst()) |-> $stable(mode_q));

  function automatic logic mode_we_or_rst();
    return we;
  endfunction

endmodule

// File: rtl/dsc_tick_gen.sv
module dsc_tick_gen #(
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] psel,
  output logic       tick
);

  localparam int MAXDIV = BASE_DIV * 64;
  localparam int CW     = $clog2(MAXDIV + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (psel)
      2'd0:    lim = CW'(BASE_DIV - 1);
      2'd1:    lim = CW'(BASE_DIV * 4 - 1);
      2'd2:    lim = CW'(BASE_DIV * 16 - 1);
      default: lim = CW'(BASE_DIV * 64 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAXDIV - 1));

endmodule

// File: rtl/dsc_tx.sv
module dsc_tx #(
  parameter int DW = 8,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync,
  input  logic [3:0]    nbits,
  input  logic          par_on,
  input  logic          par_odd,
  input  logic          two_stop,
  input  logic          tick,
  input  logic          we,
  input  logic [DW-1:0] din,
  output logic          ready,
  output logic          ser_out,
  output logic          sclk,
  output logic          samp
);

  logic [FW-1:0] frm;
  logic [3:0]    flen;
  logic [DW-1:0] dmask;
  logic          pbit;
  logic [3:0]    ppos;

  logic          busy;
  logic          fr_sync;
  logic [FW-1:0] sh;
  logic [3:0]    left;
  logic [3:0]    sub;

  // frame image, LSB goes out first; unused tail stays high
  always_comb begin
    frm   = '1;
    dmask = (nbits == 4'd7) ? 8'h7F : 8'hFF;
    pbit  = (^(din & dmask)) ^ par_odd;
    ppos  = nbits + 4'd1;
    if (sync) begin
      frm[DW-1:0] = din;
      flen        = 4'(DW);
    end else begin
      frm[0] = 1'b0;
      for (int i = 0; i < DW; i++) begin
        if (i < int'(nbits)) frm[i+1] = din[i];
      end
      if (par_on) frm[ppos] = pbit;
      flen = 4'd2 + nbits + {3'b0, par_on} + {3'b0, two_stop};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      fr_sync <= 1'b0;
      sh      <= '1;
      left    <= '0;
      sub     <= '0;
      sclk    <= 1'b1;
      samp    <= 1'b0;
    end else begin
      samp <= 1'b0;
      if (!busy) begin
        if (we) begin
          busy    <= 1'b1;
          fr_sync <= sync;
          sh      <= frm;
          left    <= flen;
          sub     <= '0;
          sclk    <= !sync;
        end
      end else if (tick) begin
        sub <= sub + 1'b1;
        if (sub == 4'd7 && fr_sync) begin
          sclk <= 1'b1;
          samp <= 1'b1;
        end
        if (sub == 4'd15) begin
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - 1'b1;
          if (left == 4'd1) busy <= 1'b0;
          else if (fr_sync) sclk <= 1'b0;
        end
      end
    end
  end

  assign ready   = !busy;
  assign ser_out = sh[0];

  // R2
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ser_out && sclk));

  // R8
  async_sclk_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fr_sync) |-> sclk);

  // R9
  busy_load_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(sh));

endmodule

// File: rtl/dsc_rx.sv
module dsc_rx
  import dsc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync,
  input  logic [3:0]    nbits,
  input  logic          par_on,
  input  logic          par_odd,
  input  logic          tick,
  input  logic          samp,
  input  logic          ser_in,
  output logic [DW-1:0] data,
  output logic          done,
  output logic          perr
);

  logic          s1, s2;
  dsc_rx_st_e    st;
  logic [DW-1:0] sh;
  logic [3:0]    cnt;
  logic [3:0]    sub;
  logic [2:0]    scnt;
  logic          pbit;
  logic [DW-1:0] dat;

  assign dat = (nbits == 4'd7) ? {1'b0, sh[DW-1:1]} : sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= ser_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      sh   <= '0;
      cnt  <= '0;
      sub  <= '0;
      scnt <= '0;
      pbit <= 1'b0;
      data <= '0;
      done <= 1'b0;
      perr <= 1'b0;
    end else begin
      done <= 1'b0;
      perr <= 1'b0;
      if (sync) begin
        st <= RX_IDLE;
        if (samp) begin
          sh   <= {s2, sh[DW-1:1]};
          scnt <= scnt + 1'b1;
          if (scnt == 3'd7) begin
            data <= {s2, sh[DW-1:1]};
            done <= 1'b1;
          end
        end
      end else begin
        scnt <= '0;
        case (st)
          RX_IDLE: begin
            if (!s2) begin
              st  <= RX_START;
              sub <= '0;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (tick) begin
              if (sub == 4'd7) begin
                sub <= '0;
                st  <= s2 ? RX_IDLE : RX_DATA;
              end else begin
                sub <= sub + 1'b1;
              end
            end
          end
          RX_DATA: begin
            if (tick) begin
              if (sub == 4'd15) begin
                sub <= '0;
                sh  <= {s2, sh[DW-1:1]};
                cnt <= cnt + 1'b1;
                if (cnt == nbits - 4'd1) st <= par_on ? RX_PAR : RX_STOP;
              end else begin
                sub <= sub + 1'b1;
              end
            end
          end
          RX_PAR: begin
            if (tick) begin
              if (sub == 4'd15) begin
                sub  <= '0;
                pbit <= s2;
                st   <= RX_STOP;
              end else begin
                sub <= sub + 1'b1;
              end
            end
          end
          RX_STOP: begin
            if (tick) begin
              if (sub == 4'd15) begin
                sub  <= '0;
                data <= dat;
                done <= 1'b1;
                perr <= par_on && (pbit != ((^dat) ^ par_odd));
                st   <= RX_IDLE;
              end else begin
                sub <= sub + 1'b1;
              end
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R5
  perr_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    perr |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  sync_no_perr_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(sync)) |-> !perr);

  // R3
  seven_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(!sync && nbits == 4'd7)) |-> !data[DW-1]);

endmodule

// File: rtl/duplex_serial_chan.sv
module duplex_serial_chan
  import dsc_pkg::*;
#(
  parameter int BASE_DIV = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic [7:0]    mode_wdata,
  output logic [7:0]    mode_rdata,
  input  logic          tx_we,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_done,
  output logic          rx_perr,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          sclk_out
);

  localparam int FW = DW + 4;

  dsc_cfg_t cfg;
  logic     tick;
  logic     samp;

  dsc_mode_reg #(.MW(8)) u_mode (
    .clk   (clk),
    .rst   (rst),
    .we    (mode_we),
    .wdata (mode_wdata),
    .rdata (mode_rdata),
    .cfg   (cfg)
  );

  dsc_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .psel (cfg.psel),
    .tick (tick)
  );

  dsc_tx #(.DW(DW), .FW(FW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .sync     (cfg.sync),
    .nbits    (cfg.nbits),
    .par_on   (cfg.par_on),
    .par_odd  (cfg.par_odd),
    .two_stop (cfg.two_stop),
    .tick     (tick),
    .we       (tx_we),
    .din      (tx_data),
    .ready    (tx_ready),
    .ser_out  (ser_out),
    .sclk     (sclk_out),
    .samp     (samp)
  );

  dsc_rx #(.DW(DW)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .sync    (cfg.sync),
    .nbits   (cfg.nbits),
    .par_on  (cfg.par_on),
    .par_odd (cfg.par_odd),
    .tick    (tick),
    .samp    (samp),
    .ser_in  (ser_in),
    .data    (rx_data),
    .done    (rx_done),
    .perr    (rx_perr)
  );

endmodule

// File: tb/duplex_serial_chan_bench.sv
module duplex_serial_chan_bench;

  localparam int BD = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       tx_we = 1'b0;
  logic [7:0] tx_data = '0;
  logic       line_sel = 1'b0;
  logic       bline = 1'b1;
  logic [7:0] mode_rdata, rx_data;
  logic       tx_ready, rx_done, rx_perr, ser_out, sclk_out, ser_in;

  always #5 clk = ~clk;

  assign ser_in = line_sel ? bline : ser_out;

  duplex_serial_chan #(.BASE_DIV(BD), .DW(8)) u_duplex_serial_chan (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .tx_we(tx_we), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_done(rx_done),
    .rx_perr(rx_perr), .ser_in(ser_in), .ser_out(ser_out), .sclk_out(sclk_out)
  );

  int cyc = 0, nchk = 0, nfail = 0, ndone = 0, nfall = 0;
  logic [8:0] expq[$];
  logic [7:0] cur_mode = '0;
  logic prev_done = 1'b0, prev_sclk = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tbit(input logic [1:0] ps);
    return 16 * BD * (1 << (2 * ps));
  endfunction

  function automatic int mk(input logic [7:0] m, input logic [7:0] d, output logic [11:0] b);
    int n, nd;
    logic [7:0] md;
    b = '1; n = 0;
    nd = m[6] ? 7 : 8;
    md = m[6] ? (d & 8'h7F) : d;
    b[n] = 1'b0; n = n + 1;
    for (int i = 0; i < nd; i++) begin b[n] = d[i]; n = n + 1; end
    if (m[5]) begin b[n] = (^md) ^ m[4]; n = n + 1; end
    b[n] = 1'b1; n = n + 1;
    if (m[3]) begin b[n] = 1'b1; n = n + 1; end
    return n;
  endfunction

  // monitor: scoreboard pops on each received character
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_done && prev_done) chk(1'b0, "R10 done wider than one cycle", 1, 0);
      if (rx_done) begin
        logic [8:0] e;
        ndone++;
        if (expq.size() == 0) chk(1'b0, "R10 unexpected character", {rx_perr, rx_data}, 0);
        else begin
          e = expq.pop_front();
          chk({rx_perr, rx_data} == e, "R5 R10 received result", {rx_perr, rx_data}, e);
        end
      end
      if (prev_sclk && !sclk_out) nfall++;
    end
    prev_done <= rx_done;
    prev_sclk <= sclk_out;
  end

  task automatic setmode(input logic [7:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
    cur_mode = m;
    chk(mode_rdata == m, "R1 mode readback", mode_rdata, m);
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_we = 1'b1;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic tx_async(input logic [7:0] d, input string req);
    logic [11:0] eb, got, msk;
    int n, T, t0, dur, dv;
    n  = mk(cur_mode, d, eb);
    T  = tbit(cur_mode[1:0]);
    dv = BD * (1 << (2 * cur_mode[1:0]));
    msk = 12'((1 << n) - 1);
    expq.push_back({1'b0, cur_mode[6] ? (d & 8'h7F) : d});
    chk(tx_ready && ser_out, "R2 idle before frame", {tx_ready, ser_out}, 3);
    send(d);
    while (ser_out) @(negedge clk);
    t0 = cyc;
    repeat (T / 2) @(negedge clk);
    got = '1;
    for (int i = 0; i < n; i++) begin
      got[i] = ser_out;
      if (i < n - 1) repeat (T) @(negedge clk);
    end
    while (!tx_ready) @(negedge clk);
    dur = cyc - t0;
    chk((got & msk) == (eb & msk), req, got & msk, eb & msk);
    chk((dur <= n * T + 2) && (dur >= n * T - dv - 2), "R7 R6 frame duration", dur, n * T);
    repeat (T) @(negedge clk);
  endtask

  task automatic drive(input logic [11:0] b, input int n, input logic [8:0] e);
    int T;
    T = tbit(cur_mode[1:0]);
    expq.push_back(e);
    line_sel = 1'b1;
    for (int i = 0; i < n; i++) begin
      bline = b[i];
      repeat (T) @(negedge clk);
    end
    bline = 1'b1;
    repeat (2 * T) @(negedge clk);
    line_sel = 1'b0;
  endtask

  task automatic tx_sync(input logic [7:0] d);
    logic [7:0] got;
    int f0;
    f0 = nfall;
    expq.push_back({1'b0, d});
    send(d);
    for (int i = 0; i < 8; i++) begin
      while (!sclk_out) @(negedge clk);
      got[i] = ser_out;
      if (i < 7) while (sclk_out) @(negedge clk);
    end
    while (!tx_ready) @(negedge clk);
    repeat (64) @(negedge clk);
    chk(got == d, "R8 sync bits LSB first", got, d);
    chk(nfall - f0 == 8, "R8 eight clock pulses", nfall - f0, 8);
  endtask

  initial begin
    logic [11:0] b;
    int n, d0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(mode_rdata == 8'h00, "R1 reset value", mode_rdata, 0);
    chk(tx_ready == 1'b1, "R2 ready after reset", tx_ready, 1);
    chk(ser_out == 1'b1, "R2 line idles high", ser_out, 1);
    chk(sclk_out == 1'b1, "R2 clock idles high", sclk_out, 1);
    chk(rx_done == 1'b0, "R10 no done after reset", rx_done, 0);

    setmode(8'h00); tx_async(8'h5A, "R2 8N1 frame"); tx_async(8'h81, "R2 8N1 frame");
    setmode(8'h40); tx_async(8'hC5, "R3 seven-bit frame");
    setmode(8'h20); tx_async(8'h03, "R4 even parity frame");
    setmode(8'h30); tx_async(8'h03, "R4 odd parity frame");
    setmode(8'h10); tx_async(8'h5A, "R5 odd bit ignored without parity");
    setmode(8'h70); tx_async(8'h81, "R3 R4 seven-bit odd frame");
    setmode(8'h08); tx_async(8'h3C, "R6 two stop bits");

    // R5: bench-driven receive with wrong and right parity
    setmode(8'h20);
    n = mk(8'h20, 8'h03, b); b[9] = ~b[9]; drive(b, n, {1'b1, 8'h03});
    n = mk(8'h20, 8'h03, b); drive(b, n, {1'b0, 8'h03});
    setmode(8'h70);
    n = mk(8'h70, 8'h05, b); b[8] = ~b[8]; drive(b, n, {1'b1, 8'h05});
    setmode(8'h10);
    n = mk(8'h10, 8'hA7, b); drive(b, n, {1'b0, 8'hA7});

    // R9: strobe while busy is dropped
    setmode(8'h00);
    d0 = ndone;
    expq.push_back({1'b0, 8'h11});
    send(8'h11);
    repeat (40) @(negedge clk);
    chk(tx_ready == 1'b0, "R9 busy during frame", tx_ready, 0);
    send(8'h22);
    while (!tx_ready) @(negedge clk);
    repeat (6 * tbit(2'd0)) @(negedge clk);
    chk(ser_out && tx_ready, "R9 no second frame", {ser_out, tx_ready}, 3);
    chk(ndone - d0 == 1, "R9 exactly one character", ndone - d0, 1);

    // R8: sync mode ignores length and parity bits
    setmode(8'hE0); tx_sync(8'hA5);
    setmode(8'h80); tx_sync(8'h3C);

    // R7: prescaler settings
    setmode(8'h01); tx_async(8'h96, "R7 divide by 4 frame");
    setmode(8'h03); tx_async(8'h69, "R7 divide by 64 frame");

    repeat (200) @(negedge clk);
    chk(expq.size() == 0, "R10 all characters received", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule